// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Selectable Request Control

This block issues refresh cycles to a DRAM array built from several banks. A prescaler divides the system clock into a slow tick. An interval counter turns the ticks into periodic refresh requests. A sequencer drives one row-address strobe per bank for each refresh cycle. A row counter supplies the next row to refresh and advances once per cycle.

Three control schemes are available. In the self-timed scheme, every interval request starts a refresh as soon as the sequencer is idle. In the host-burst scheme, the interval requests are inhibited and the host starts refreshes by holding its refresh input high. Refreshes then run back to back. In the handshake scheme, the interval request is shown on an output and waits there until the host starts a refresh.

Two refresh kinds are available:
- **All-bank:** every bank strobes together. The strobe width can be stretched by whole clock periods. A scrub window can be opened over the cycle.
- **Staggered:** the banks start one clock apart. This kind has no stretch and no scrub window. Selecting staggered together with scrub puts the row counter in a split test mode: its low and high fields step independently.

Top module: `rfsh_ctrl`

## Requirements
- R1: After reset, all of the following are 0: `ras`, `rfip`, `refresh_req`, `scrub_active` and `row_addr`.
- R2: The self-timed scheme is selected by `disable_auto`=0 and `req_ack_mode`=0. In this scheme `rfip` first rises TICK_DIV*REQ_TICKS+1 clock edges after reset. After that it rises every TICK_DIV*REQ_TICKS cycles. `host_refresh` held for fewer than TICK_DIV cycles starts no refresh.
- R3: With `disable_auto`=1, no refresh ever starts on its own. While the sequencer is idle, `host_refresh`=1 starts a refresh at the next clock edge. Holding `host_refresh` high gives back-to-back refreshes separated by exactly one idle cycle.
- R4: The handshake scheme is selected by `req_ack_mode`=1 and `disable_auto`=0. In this scheme `refresh_req` rises TICK_DIV*REQ_TICKS edges after reset. It stays high and no refresh runs until `host_refresh` is seen while idle. It falls in the same cycle that `rfip` rises.
- R5: In the self-timed scheme, `host_refresh` held high for TICK_DIV consecutive cycles clears the timebase and any pending request. The next `rfip` rises TICK_DIV*REQ_TICKS+1 edges after the clearing edge.
- R6: All-bank refresh is selected by `stagger_sel`=0. In this kind every bit of `ras` is high for RAS_CYCLES+`extend_cycles` cycles. The value of `extend_cycles` is taken when the refresh starts.
- R7: Staggered refresh is selected by `stagger_sel`=1. In cycle k of the refresh (k counted from 0), `ras[i]` is high when i <= k < i+RAS_CYCLES. The refresh lasts NUM_BANKS-1+RAS_CYCLES cycles and ignores `extend_cycles`.
- R8: `rfip` is high from the first cycle with any `ras` bit high until the last such cycle, including the stretch. It is low otherwise.
- R9: `scrub_active` equals `rfip` during an all-bank refresh started with `scrub_en`=1. It is low in every other cycle.
- R10: Outside test mode, `row_addr` rises by one (modulo 2^(LO_W+HI_W)) for each refresh.
- R11: Test mode means a refresh started with `stagger_sel`=1 and `scrub_en`=1. In test mode the low LO_W bits and the high HI_W bits of `row_addr` each rise by one modulo their own width, with no carry between them.
- R12: An interval expiry can fall in the same cycle as a refresh start. In that case the new request survives: `refresh_req` in the handshake scheme is high in the first cycle of that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_auto | input | 1 | 1 inhibits self-timed requests (host-burst scheme) |
| req_ack_mode | input | 1 | 1 selects the handshake scheme |
| host_refresh | input | 1 | Host refresh start; in the self-timed scheme, a long hold clears the timebase |
| stagger_sel | input | 1 | 0 all-bank refresh, 1 staggered refresh |
| scrub_en | input | 1 | Scrub window request (all-bank), or test mode with staggered |
| extend_cycles | input | EXT_W | Extra strobe cycles for all-bank refresh |
| ras | output | NUM_BANKS | Per-bank refresh row strobe, active high |
| rfip | output | 1 | Refresh in progress |
| refresh_req | output | 1 | Pending interval request (handshake scheme) |
| scrub_active | output | 1 | Scrub window open |
| row_addr | output | LO_W+HI_W | Row to be refreshed next |

## Verification
Two functions can fall in the same cycle: the interval timer expiring, and a refresh starting, which clears the pending request. Expiry wins, so the request survives.

The bench provokes the collision in the handshake scheme. It services the first request early. It then raises the host input in exactly the cycle before the next known expiry edge. The check is that the refresh starts and `refresh_req` is still high in its first cycle. If the start's clear were allowed to win, `refresh_req` would read low there.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} sq_state_e;
  typedef enum logic {KIND_ALL = 1'b0, KIND_STAG = 1'b1} rf_kind_e;
endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase #(
  parameter int TICK_DIV  = 16,
  parameter int REQ_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_cond,
  output logic expire,
  output logic clr_pulse
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int IW = (REQ_TICKS > 1) ? $clog2(REQ_TICKS) : 1;
  localparam int HW = $clog2(TICK_DIV + 1);

  logic [PW-1:0] pre_q;
  logic [IW-1:0] ivl_q;
  logic [HW-1:0] hold_q;
  logic          tick;

  assign tick      = (pre_q == PW'(TICK_DIV - 1));
  assign clr_pulse = clr_cond && (hold_q == HW'(TICK_DIV - 1));
  assign expire    = tick && (ivl_q == IW'(REQ_TICKS - 1)) && !clr_pulse;

  // consecutive-cycle counter for the clear condition, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hold_q <= '0;
    else if (!clr_cond)             hold_q <= '0;
    else if (hold_q != HW'(TICK_DIV)) hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ivl_q <= '0;
    end else if (clr_pulse) begin
      pre_q <= '0;
      ivl_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      ivl_q <= (ivl_q == IW'(REQ_TICKS - 1)) ? '0 : ivl_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) < TICK_DIV); // R2
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (pre_q == '0) && (ivl_q == '0)); // R5
endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import rfsh_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int RAS_CYCLES = 3,
  parameter int EXT_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  rf_kind_e             kind,
  input  logic [EXT_W-1:0]     ext_len,
  input  logic                 scrub_req,
  output logic [NUM_BANKS-1:0] ras,
  output logic                 busy,
  output logic                 last,
  output logic                 scrub_active
);
  localparam int STAG_LEN = NUM_BANKS - 1 + RAS_CYCLES;
  localparam int LEN_W    = $clog2(RAS_CYCLES + (1 << EXT_W) + NUM_BANKS);

  function automatic logic [LEN_W-1:0] span_last(rf_kind_e k, logic [EXT_W-1:0] e);
    if (k == KIND_STAG) return LEN_W'(STAG_LEN - 1);
    return LEN_W'(RAS_CYCLES - 1) + LEN_W'(e);
  endfunction

  function automatic logic bank_on(int b, logic [LEN_W-1:0] c, rf_kind_e k);
    if (k == KIND_ALL) return 1'b1;
    return (int'(c) >= b) && (int'(c) < b + RAS_CYCLES);
  endfunction

  sq_state_e        state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  rf_kind_e         kind_q;
  logic             scrub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      kind_q  <= KIND_ALL;
      scrub_q <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_RUN;
          cnt_q   <= '0;
          len_q   <= span_last(kind, ext_len);
          kind_q  <= kind;
          scrub_q <= scrub_req && (kind == KIND_ALL);
        end
        default: begin
          if (cnt_q == len_q) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            scrub_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy         = (state_q == SQ_RUN);
  assign last         = busy && (cnt_q == len_q);
  assign scrub_active = busy && scrub_q;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign ras[i] = busy && bank_on(i, cnt_q, kind_q);
  end

  AST_BUSY_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (|ras)); // R8
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= len_q)); // R6
  AST_STAG_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == KIND_STAG) |-> ($countones(ras & ~$past(ras)) <= 1)); // R7
  AST_SCRUB_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_active |-> (&ras)); // R9
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int LO_W = 13,
  parameter int HI_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 split,
  output logic [LO_W+HI_W-1:0] row
);
  localparam int ROW_W = LO_W + HI_W;

  function automatic logic [ROW_W-1:0] row_next(logic [ROW_W-1:0] r, logic s);
    logic [LO_W-1:0] lo;
    logic [HI_W-1:0] hi;
    if (!s) return r + 1'b1;
    lo = r[LO_W-1:0] + 1'b1;
    hi = r[ROW_W-1:LO_W] + 1'b1;
    return {hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row_next(row, split);
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !split) |=> (row == $past(row) + 1'b1)); // R10
  AST_SPLIT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && split) |=> (row[LO_W-1:0] == $past(row[LO_W-1:0]) + 1'b1)); // R11
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row)); // R10
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int RAS_CYCLES = 3,
  parameter int EXT_W      = 3,
  parameter int TICK_DIV   = 16,
  parameter int REQ_TICKS  = 30,
  parameter int LO_W       = 13,
  parameter int HI_W       = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disable_auto,
  input  logic                 req_ack_mode,
  input  logic                 host_refresh,
  input  logic                 stagger_sel,
  input  logic                 scrub_en,
  input  logic [EXT_W-1:0]     extend_cycles,
  output logic [NUM_BANKS-1:0] ras,
  output logic                 rfip,
  output logic                 refresh_req,
  output logic                 scrub_active,
  output logic [LO_W+HI_W-1:0] row_addr
);
  logic auto_mode, clr_cond, expire, clr_pulse;
  logic pending_q, start, busy, last;
  rf_kind_e kind;

  assign auto_mode = !disable_auto && !req_ack_mode;
  assign clr_cond  = auto_mode && host_refresh;
  assign kind      = rf_kind_e'(stagger_sel);

  rfsh_timebase #(.TICK_DIV(TICK_DIV), .REQ_TICKS(REQ_TICKS)) u_tb (
    .clk(clk), .rst_n(rst_n), .clr_cond(clr_cond),
    .expire(expire), .clr_pulse(clr_pulse)
  );

  // start arbitration: self-timed uses the held request, others the host input
  assign start = !busy && (auto_mode ? pending_q : host_refresh);

  // a fresh expiry outranks the clear caused by a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pending_q <= 1'b0;
    else if (expire && !disable_auto)     pending_q <= 1'b1;
    else if (start || clr_pulse)          pending_q <= 1'b0;
  end

  rfsh_sequencer #(.NUM_BANKS(NUM_BANKS), .RAS_CYCLES(RAS_CYCLES), .EXT_W(EXT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .ext_len(extend_cycles), .scrub_req(scrub_en),
    .ras(ras), .busy(busy), .last(last), .scrub_active(scrub_active)
  );

  rfsh_row_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_row (
    .clk(clk), .rst_n(rst_n), .step(start),
    .split(stagger_sel && scrub_en), .row(row_addr)
  );

  assign rfip        = busy;
  assign refresh_req = pending_q && req_ack_mode;

  AST_REQ_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !expire && req_ack_mode) |=> !refresh_req); // R4
  AST_EXPIRE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && expire && !disable_auto) |=> pending_q); // R12
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !pending_q); // R5
  AST_AUTO_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rfip) && $past(auto_mode)) |-> $past(pending_q)); // R2
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !rfip); // R3
endmodule

// File: tb/tb_rfsh_ctrl.sv
`timescale 1ns/1ps
module tb_rfsh_ctrl;
  localparam int NB = 4, RC = 3, EW = 3, TD = 4, RT = 8, LW = 5, HWD = 3;
  localparam int PER = TD * RT;

  logic clk = 0, rst_n = 0;
  logic disable_auto = 0, req_ack_mode = 0, host_refresh = 0, stagger_sel = 0, scrub_en = 0;
  logic [EW-1:0] extend_cycles = '0;
  logic [NB-1:0] ras;
  logic rfip, refresh_req, scrub_active;
  logic [LW+HWD-1:0] row_addr;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  rfsh_ctrl #(.NUM_BANKS(NB), .RAS_CYCLES(RC), .EXT_W(EW), .TICK_DIV(TD),
              .REQ_TICKS(RT), .LO_W(LW), .HI_W(HWD)) dut (
    .clk(clk), .rst_n(rst_n), .disable_auto(disable_auto), .req_ack_mode(req_ack_mode),
    .host_refresh(host_refresh), .stagger_sel(stagger_sel), .scrub_en(scrub_en),
    .extend_cycles(extend_cycles), .ras(ras), .rfip(rfip), .refresh_req(refresh_req),
    .scrub_active(scrub_active), .row_addr(row_addr));

  function automatic int exp_len(bit stag, int ext);
    return stag ? (NB - 1 + RC) : (RC + ext);
  endfunction
  function automatic bit exp_bank(bit stag, int k, int b);
    return stag ? (k >= b && k - b < RC) : 1'b1;
  endfunction
  function automatic int exp_row(int r, bit split);
    int lo, hi;
    if (!split) return (r + 1) % (1 << (LW + HWD));
    lo = ((r % (1 << LW)) + 1) % (1 << LW);
    hi = ((r >> LW) + 1) % (1 << HWD);
    return hi * (1 << LW) + lo;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; disable_auto = 0; req_ack_mode = 0; host_refresh = 0;
    stagger_sel = 0; scrub_en = 0; extend_cycles = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_cyc(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    int g = 0;
    while (!rfip && g < 1000) begin @(negedge clk); g++; end
    t = cyc;
  endtask

  // called at the first negedge with rfip high; ends at first negedge with rfip low
  task automatic capture(input bit stag, input int ext, input bit scr, input string tag);
    int k = 0, errs = 0, sc = 0;
    while (rfip && k < 40) begin
      for (int b = 0; b < NB; b++)
        if (ras[b] != exp_bank(stag, k, b)) errs++;
      if (scrub_active) sc++;
      k++;
      @(negedge clk);
    end
    chk({tag, " length"}, k, exp_len(stag, ext));
    chk({tag, " strobe pattern errors"}, errs, 0);
    chk("R9 scrub window cycles", sc, (scr && !stag) ? k : 0);
  endtask

  task automatic burst_run(input int n, input bit stag);
    int rises = 1, prev = 1, last_t, gap_err = 0;
    host_refresh = 1;
    @(negedge clk);
    chk("R3 host start next edge", rfip, 1);
    last_t = cyc;
    while (rises < n) begin
      @(negedge clk);
      if (rfip && !prev) begin
        rises++;
        if (cyc - last_t != exp_len(stag, 0) + 1) gap_err++;
        last_t = cyc;
      end
      prev = rfip;
    end
    host_refresh = 0;
    chk("R3 back-to-back spacing errors", gap_err, 0);
    while (rfip) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t1, t2, r, seen;
    bit stg, scr;
    int ext;
    void'($urandom(32'd4242));

    // R1 reset
    do_reset();
    @(negedge clk);
    chk("R1 ras", ras, 0); chk("R1 rfip", rfip, 0); chk("R1 req", refresh_req, 0);
    chk("R1 scrub", scrub_active, 0); chk("R1 row", row_addr, 0);

    // R2 self-timed first refresh
    wait_rise(t1);
    chk("R2 first refresh edge", t1, PER + 1);
    capture(0, 0, 0, "R6 all-bank");
    chk("R10 row after one", row_addr, 1);
    // short host pulse in self-timed scheme must start nothing
    host_refresh = 1; seen = 0;
    repeat (TD - 1) begin @(negedge clk); if (rfip) seen++; end
    host_refresh = 0;
    chk("R2 short host pulse ignored", seen, 0);
    wait_rise(t2);
    chk("R2 interval", t2 - t1, PER);
    capture(0, 0, 0, "R6 all-bank");

    // random kinds, stretch and scrub in self-timed scheme
    for (int it = 0; it < 10; it++) begin
      ext = $urandom % (1 << EW); stg = 1'($urandom % 2); scr = 1'($urandom % 2);
      extend_cycles = EW'(ext); stagger_sel = stg; scrub_en = scr;
      r = row_addr; t1 = t2;
      wait_rise(t2);
      chk("R2 interval", t2 - t1, PER);
      capture(stg, ext, scr, stg ? "R7 staggered" : "R6 R8 all-bank");
      chk(stg && scr ? "R11 split row" : "R10 row step", row_addr, exp_row(r, stg && scr));
    end

    // R5 clear
    do_reset();
    wait_rise(t1);
    capture(0, 0, 0, "R6 all-bank");
    wait_cyc(45);
    host_refresh = 1; seen = 0;
    repeat (TD) begin @(negedge clk); if (rfip) seen++; end
    host_refresh = 0;
    chk("R5 clear hold starts nothing", seen, 0);
    wait_cyc(PER * 2 + 1);
    chk("R5 old schedule gone", rfip, 0);
    wait_cyc(49 + PER);
    chk("R5 before restarted expiry", rfip, 0);
    wait_cyc(49 + PER + 1);
    chk("R5 refresh after clear", rfip, 1);

    // R3 host burst, R10 row count
    do_reset();
    disable_auto = 1; seen = 0;
    repeat (3 * PER) begin @(negedge clk); if (rfip) seen++; end
    chk("R3 no self-timed refresh", seen, 0);
    burst_run(40, 0);
    chk("R10 row after 40", row_addr, 40);

    // R11 split test mode
    do_reset();
    disable_auto = 1; stagger_sel = 1; scrub_en = 1;
    @(negedge clk);
    burst_run(40, 1);
    chk("R11 split row after 40", row_addr, 8);

    // R4 handshake and R12 collision
    do_reset();
    req_ack_mode = 1;
    wait_cyc(PER - 1);
    chk("R4 req before expiry", refresh_req, 0);
    wait_cyc(PER);
    chk("R4 req raised", refresh_req, 1);
    wait_cyc(PER + 10);
    chk("R4 no refresh without host", rfip, 0);
    chk("R4 req held", refresh_req, 1);
    host_refresh = 1;
    @(negedge clk);
    host_refresh = 0;
    chk("R4 refresh started", rfip, 1);
    chk("R4 req falls at start", refresh_req, 0);
    wait_cyc(2 * PER - 1);
    host_refresh = 1;
    @(negedge clk);
    host_refresh = 0;
    chk("R12 refresh started on expiry edge", rfip, 1);
    chk("R12 req survives collision", refresh_req, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule